// File: doc/BRIEF.md
# SPI Master Controller with Control Register

This block is a serial peripheral interface controller that software sets up through a single control register. A small host port gives access to four byte-wide locations: the control register (address 0), the slave-select register (address 1), the data port (address 2) and the status register (address 3). A write to the data port queues a byte in the transmit FIFO. A read of the data port shows the oldest received byte, and asserting `host_re` at that address removes it from the receive FIFO.

When the controller is enabled in the master role, it starts a transfer on its own as soon as a byte is waiting in the transmit FIFO. Each word is eight bits long and is shifted most significant bit first. SCK runs at the system clock divided by `DIV`. Slave select is either generated around each burst of words or driven straight from the slave-select register. A loopback mode connects the shift output to the shift input and ignores the pin input. Every pad output comes with its own output enable, so the pads can be tri-stated.

Top module: `spi_ctl_top`

## Requirements
- R1: After reset, every output enable is low, `ss_n_o` is all ones, the control register reads 0x00, and status reads 0x0A. The status bits are: bit0 transmit full, bit1 transmit empty, bit2 receive full, bit3 receive empty, bit4 overrun.
- R2: While the enable bit (control bit0) is 0, every output enable stays low, queued transmit data is not consumed, and `ss_i` has no effect on `miso_oe`.
- R3: When enabled (bit0=1) in the master role (bit1=1), `sck_oe`, `mosi_oe` and `ss_oe` are high. Between transfers SCK rests at the clock polarity bit (bit2): low for 0, high for 1.
- R4: Each word is 8 bits, MSB first. With the phase bit (bit3) at 0, MOSI and MISO are sampled on odd SCK edges and change on even edges. With bit3 at 1, they are sampled on even edges and change on odd edges. The received byte equals the MISO bits in the order they were sampled.
- R5: A word takes exactly 16 SCK edges, spaced DIV/2 clock cycles apart. The first edge comes DIV/2 cycles after slave select asserts.
- R6: With manual select (bit6) at 0, `ss_n_o` equals the slave-select register only while a burst runs, and is all ones otherwise. It stays asserted across back-to-back words, so there is one assertion per burst.
- R7: With bit6 at 1 and the controller enabled as master, `ss_n_o` follows the slave-select register at all times, including while a transfer runs.
- R8: In the slave role (bit1=0), `ss_n_o` is all ones and `ss_oe`, `sck_oe` and `mosi_oe` are low, whatever the value of bit6.
- R9: With loopback (bit7) set in the master role, each received byte equals the byte transmitted, whatever level `miso_i` has.
- R10: Writing 1 to transmit clear (bit4) or receive clear (bit5) empties that FIFO on the next clock edge. The bit reads 1 for one cycle and then returns to 0 by itself.
- R11: A data-port write while the transmit FIFO holds `DEPTH` bytes is dropped.
- R12: A byte received while the receive FIFO is full is discarded and sets overrun (status bit4). Overrun stays set until the host writes status with bit4=1.
- R13: `miso_oe` is high only when the controller is enabled, in the slave role, and `ss_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 2 | Register address |
| host_we | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_re | input | 1 | Read strobe; pops the receive FIFO at address 2 |
| host_rdata | output | 8 | Read data for `host_addr` |
| sck_o | output | 1 | Serial clock |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Serial data out enable |
| miso_i | input | 1 | Serial data in |
| miso_o | output | 1 | Slave-role data out (head of transmit FIFO, bit 7) |
| miso_oe | output | 1 | Slave-role data out enable |
| ss_i | input | 1 | Slave-role select input, active low |
| ss_n_o | output | NSLV | Slave select outputs, active low |
| ss_oe | output | 1 | Slave select output enable |

## Verification
The bench runs all four polarity and phase combinations. For each one it sends four words back to back, using data that includes all zeros and all ones. A bench-side slave model captures MOSI on the sample edges and drives MISO on the change edges. This exposes a design that samples on the wrong edge, which would corrupt data in both directions by one bit. It also exposes one that drops slave select between words, which would show more than one assertion per burst.

Edge spacing and the delay from slave select to the first edge are measured in clock cycles, which catches an off-by-one half period. The bench fills the FIFOs past their depth to confirm that the extra transmit byte is lost, that the fifth received byte is dropped while the first four survive, and that overrun stays set after reads. It also reads the clear bits on the cycle after the write and on the cycle after that, so a bit that does not clear itself, or a flush that lands a cycle late, is reported.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

    localparam int unsigned WORD_W = 8;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_SSEL = 2'd1;
    localparam logic [1:0] ADR_DATA = 2'd2;
    localparam logic [1:0] ADR_STAT = 2'd3;

    // control register layout, MSB first
    typedef struct packed {
        logic loop;
        logic man_ss;
        logic rx_clr;
        logic tx_clr;
        logic cpha;
        logic cpol;
        logic master;
        logic en;
    } ctrl_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } xfer_st_e;

endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t     st_d, st_q;
    logic [W-1:0] mem_d [DEPTH];
    logic [W-1:0] mem_q [DEPTH];
    logic         do_push, do_pop;

    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign rdata = mem_q[st_q.rp];

    always_comb begin
        st_d    = st_q;
        mem_d   = mem_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) begin
                mem_d[st_q.wp] = wdata;
                st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
            end
            if (do_pop) begin
                st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
            end
            st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            st_q  <= st_d;
            mem_q <= mem_d;
        end
    end

    // R11: occupancy never exceeds the depth
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // R11: a push into a full FIFO without a pop leaves it full
    a_r11_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> full);

    // R10: a flush leaves the FIFO empty on the next cycle
    a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_ctl_pkg::*;
#(
    parameter int unsigned DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              cpha,
    input  logic              loop,
    input  logic              miso,
    input  logic              tx_empty,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    output logic              busy,
    output logic              sck_ph,
    output logic              mosi
);
    localparam int unsigned HALF  = DIV / 2;
    localparam int unsigned HCW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int unsigned EDGES = 2 * WORD_W;
    localparam int unsigned HW    = $clog2(EDGES + 1);

    typedef struct packed {
        xfer_st_e          st;
        logic [HCW-1:0]    cnt;
        logic [HW-1:0]     h;
        logic              sck;
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
    } eng_t;

    eng_t        q, d;
    logic [HW-1:0] edge_n;
    logic        samp;
    logic        rx_in;

    assign busy   = (q.st == ST_RUN);
    assign sck_ph = q.sck;
    assign mosi   = q.tx[WORD_W-1];

    always_comb begin
        d       = q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        rx_word = q.rx;
        edge_n  = q.h + 1'b1;
        samp    = edge_n[0] ^ cpha;
        rx_in   = loop ? q.tx[WORD_W-1] : miso;
        case (q.st)
            ST_IDLE: begin
                d.sck = 1'b0;
                if (go && !tx_empty) begin
                    tx_pop = 1'b1;
                    d.tx   = tx_data;
                    d.st   = ST_RUN;
                    d.cnt  = '0;
                    d.h    = '0;
                end
            end
            default: begin
                if (!go) begin
                    d.st  = ST_IDLE;
                    d.sck = 1'b0;
                end else if (q.cnt != HCW'(HALF - 1)) begin
                    d.cnt = q.cnt + 1'b1;
                end else begin
                    d.cnt = '0;
                    if (q.h == HW'(EDGES)) begin
                        // trailing half period done: chain or stop
                        if (!tx_empty) begin
                            tx_pop = 1'b1;
                            d.tx   = tx_data;
                            d.h    = '0;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end else begin
                        d.sck = ~q.sck;
                        d.h   = edge_n;
                        if (samp) begin
                            d.rx = {q.rx[WORD_W-2:0], rx_in};
                        end else if (edge_n != HW'(1) && edge_n != HW'(EDGES)) begin
                            d.tx = {q.tx[WORD_W-2:0], 1'b0};
                        end
                        if (edge_n == HW'(EDGES)) begin
                            rx_push = 1'b1;
                            rx_word = d.rx;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R5: a word is only loaded when the transmit FIFO has data
    a_r5_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);

    // R3: the clock phase rests at zero whenever no transfer runs
    a_r3_idle_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck_ph);

    // R2: dropping go stops the engine on the next cycle
    a_r2_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> !busy);

endmodule

// File: rtl/spi_ctl_top.sv
module spi_ctl_top
    import spi_ctl_pkg::*;
#(
    parameter int unsigned DIV   = 4,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned NSLV  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      host_addr,
    input  logic            host_we,
    input  logic [7:0]      host_wdata,
    input  logic            host_re,
    output logic [7:0]      host_rdata,
    output logic            sck_o,
    output logic            sck_oe,
    output logic            mosi_o,
    output logic            mosi_oe,
    input  logic            miso_i,
    output logic            miso_o,
    output logic            miso_oe,
    input  logic            ss_i,
    output logic [NSLV-1:0] ss_n_o,
    output logic            ss_oe
);
    localparam logic [NSLV-1:0] SS_NONE = {NSLV{1'b1}};

    typedef struct packed {
        ctrl_t           ctrl;
        logic [NSLV-1:0] ssel;
        logic            ovr;
    } regs_t;

    regs_t             q, d;
    logic              run;
    logic              tx_push, tx_pop, tx_full, tx_empty;
    logic              rx_push, rx_pop, rx_full, rx_empty;
    logic [WORD_W-1:0] tx_head, rx_head, rx_word;
    logic              busy, sck_ph, mosi;
    logic              wr_ctrl, wr_ssel, wr_stat;

    assign run     = q.ctrl.en && q.ctrl.master;
    assign wr_ctrl = host_we && (host_addr == ADR_CTRL);
    assign wr_ssel = host_we && (host_addr == ADR_SSEL);
    assign wr_stat = host_we && (host_addr == ADR_STAT);
    assign tx_push = host_we && (host_addr == ADR_DATA);
    assign rx_pop  = host_re && (host_addr == ADR_DATA);

    always_comb begin
        d = q;
        d.ctrl.tx_clr = 1'b0;
        d.ctrl.rx_clr = 1'b0;
        if (wr_ctrl) d.ctrl = ctrl_t'(host_wdata);
        if (wr_ssel) d.ssel = host_wdata[NSLV-1:0];
        if (wr_stat && host_wdata[4]) d.ovr = 1'b0;
        if (rx_push && rx_full) d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ssel <= SS_NONE;
        end else begin
            q <= d;
        end
    end

    spi_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(q.ctrl.tx_clr),
        .push(tx_push), .wdata(host_wdata), .pop(tx_pop),
        .rdata(tx_head), .full(tx_full), .empty(tx_empty)
    );

    spi_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(q.ctrl.rx_clr),
        .push(rx_push), .wdata(rx_word), .pop(rx_pop),
        .rdata(rx_head), .full(rx_full), .empty(rx_empty)
    );

    spi_xfer_engine #(.DIV(DIV)) u_eng (
        .clk(clk), .rst_n(rst_n), .go(run),
        .cpha(q.ctrl.cpha), .loop(q.ctrl.loop), .miso(miso_i),
        .tx_empty(tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_word(rx_word),
        .busy(busy), .sck_ph(sck_ph), .mosi(mosi)
    );

    // pad side
    assign sck_o   = q.ctrl.cpol ^ sck_ph;
    assign sck_oe  = run;
    assign mosi_o  = mosi;
    assign mosi_oe = run;
    assign ss_oe   = run;
    assign miso_o  = tx_head[WORD_W-1];
    assign miso_oe = q.ctrl.en && !q.ctrl.master && !ss_i;

    always_comb begin
        if (!run)               ss_n_o = SS_NONE;
        else if (q.ctrl.man_ss) ss_n_o = q.ssel;
        else if (busy)          ss_n_o = q.ssel;
        else                    ss_n_o = SS_NONE;
    end

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            ADR_CTRL: host_rdata = q.ctrl;
            ADR_SSEL: host_rdata[NSLV-1:0] = q.ssel;
            ADR_DATA: host_rdata = rx_head;
            default:  host_rdata = {3'b000, q.ovr, rx_empty, rx_full, tx_empty, tx_full};
        endcase
    end

    // R3: outside a transfer the clock pin sits at the polarity level
    a_r3_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !busy) |-> (sck_o == q.ctrl.cpol));

    // R6: once a burst ends in automatic mode no slave stays selected
    a_r6_ss_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && run && !q.ctrl.man_ss) |-> (ss_n_o == SS_NONE));

    // R10: clear bits drop by themselves after one cycle
    a_r10_tx_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ctrl.tx_clr && !wr_ctrl) |=> !q.ctrl.tx_clr);
    a_r10_rx_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ctrl.rx_clr && !wr_ctrl) |=> !q.ctrl.rx_clr);

    // R12: overrun is sticky until explicitly cleared
    a_r12_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ovr && !(wr_stat && host_wdata[4])) |=> q.ovr);

    // R12: a push into a full receive FIFO raises overrun
    a_r12_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> q.ovr);

endmodule

// File: tb/sim_spi_ctl_top.sv
`timescale 1ns/1ps
module sim_spi_ctl_top;
    localparam int DIV = 4;
    localparam int HALF = DIV / 2;
    localparam int DEPTH = 4;
    localparam int NSLV = 2;

    localparam logic [1:0] A_CTRL = 2'd0, A_SSEL = 2'd1, A_DATA = 2'd2, A_STAT = 2'd3;
    localparam logic [7:0] C_EN = 8'h01, C_MST = 8'h02, C_POL = 8'h04, C_PHA = 8'h08,
                           C_TXC = 8'h10, C_RXC = 8'h20, C_MAN = 8'h40, C_LOOP = 8'h80;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] host_addr = '0;
    logic host_we = 1'b0, host_re = 1'b0, ss_i = 1'b1;
    logic [7:0] host_wdata = '0, host_rdata;
    logic sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_oe;
    logic [NSLV-1:0] ss_n_o;
    logic miso_b = 1'b0;

    always #2.5 clk = ~clk;

    spi_ctl_top #(.DIV(DIV), .DEPTH(DEPTH), .NSLV(NSLV)) u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
        .host_wdata(host_wdata), .host_re(host_re), .host_rdata(host_rdata),
        .sck_o(sck_o), .sck_oe(sck_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_b), .miso_o(miso_o), .miso_oe(miso_oe), .ss_i(ss_i),
        .ss_n_o(ss_n_o), .ss_oe(ss_oe)
    );

    int total = 0, bad = 0;
    bit done = 0;

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bench slave model
    logic [7:0] txw [16];
    logic [7:0] mpat [16];
    logic [7:0] capw [16];
    int widx = 0, ecnt = 0, mi = 7, since = 0, spc_bad = 0, nfall = 0;
    bit fresh = 0, prev_act = 0, prev_sck = 0, cpha_m = 0;
    logic [7:0] cap = '0;

    always @(negedge clk) begin
        bit act, samp;
        int expsp;
        act = ss_oe && (ss_n_o != {NSLV{1'b1}});
        since++;
        if (act && !prev_act) begin
            nfall++; ecnt = 0; fresh = 1; since = 0;
            miso_b = mpat[widx % 16][7]; mi = 6;
        end else if (act && prev_act && sck_o != prev_sck) begin
            ecnt++;
            expsp = fresh ? HALF : ((ecnt == 1) ? 2 * HALF : HALF);
            if (since != expsp) spc_bad++;
            since = 0; fresh = 0;
            samp = (ecnt % 2 == 1) ^ cpha_m;
            if (samp) cap = {cap[6:0], mosi_o};
            else if (ecnt != 1 && ecnt != 16) begin
                miso_b = mpat[widx % 16][mi]; mi--;
            end
            if (ecnt == 16) begin
                capw[widx % 16] = cap; widx++; ecnt = 0;
                miso_b = mpat[widx % 16][7]; mi = 6;
            end
        end
        prev_sck = sck_o;
        prev_act = act;
    end

    task automatic wr(logic [1:0] a, logic [7:0] v);
        @(negedge clk);
        host_addr = a; host_wdata = v; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic peek(logic [1:0] a, output logic [7:0] v);
        host_addr = a;
        #1 v = host_rdata;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        peek(a, v);
    endtask

    task automatic popr(output logic [7:0] v);
        @(negedge clk);
        peek(A_DATA, v);
        host_re = 1'b1;
        @(negedge clk);
        host_re = 1'b0;
    endtask

    task automatic wait_words(int n);
        repeat (n * 19 * HALF + 12) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] cfg;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 oe", {sck_oe, mosi_oe, ss_oe, miso_oe}, 0);
        chk("R1 ss", ss_n_o, 3);
        rd(A_CTRL, v); chk("R1 ctrl", v, 0);
        rd(A_STAT, v); chk("R1 stat", v, 8'h0A);

        // R2 disabled: nothing moves, ss_i ignored
        wr(A_SSEL, 8'h02);
        wr(A_CTRL, C_MST);
        wr(A_DATA, 8'h5A);
        ss_i = 1'b0;
        repeat (60) @(negedge clk);
        chk("R2 oe", {sck_oe, mosi_oe, ss_oe, miso_oe}, 0);
        rd(A_STAT, v); chk("R2 tx kept", v[1], 0);
        ss_i = 1'b1;

        // R10 transmit clear self-clears
        wr(A_CTRL, C_MST | C_TXC);
        peek(A_CTRL, v); chk("R10 txclr set", v[4], 1);
        @(negedge clk);
        peek(A_CTRL, v); chk("R10 txclr cleared", v[4], 0);
        peek(A_STAT, v); chk("R10 tx empty", v[1], 1);

        // R3 idle levels for both polarities
        for (int p = 0; p < 2; p++) begin
            wr(A_CTRL, C_EN | C_MST | (p ? C_POL : 8'h00));
            repeat (3) @(negedge clk);
            chk("R3 sck idle", sck_o, p);
            chk("R3 oe", {sck_oe, mosi_oe, ss_oe}, 7);
            chk("R6 idle ss", ss_n_o, 3);
        end

        // R4 R5 R6 sweep over all modes
        for (int m = 0; m < 4; m++) begin
            cfg = C_MST | (m[1] ? C_POL : 8'h00) | (m[0] ? C_PHA : 8'h00);
            wr(A_CTRL, cfg);
            cpha_m = m[0];
            for (int k = 0; k < 4; k++) begin
                txw[k] = (k == 0) ? 8'h00 : (k == 3) ? 8'hFF : 8'((m * 61 + k * 29 + 8'h35) & 8'hFF);
                mpat[k] = ~txw[k] ^ 8'(m * 17 + k);
                wr(A_DATA, txw[k]);
            end
            widx = 0; spc_bad = 0; nfall = 0;
            wr(A_CTRL, cfg | C_EN);
            wait_words(4);
            chk("R5 words seen", widx, 4);
            chk("R5 edge spacing", spc_bad, 0);
            chk("R6 one select per burst", nfall, 1);
            chk("R6 released", ss_n_o, 3);
            chk("R3 sck back idle", sck_o, m[1]);
            for (int k = 0; k < 4; k++) begin
                chk("R4 mosi word", capw[k], txw[k]);
                popr(v);
                chk("R4 miso word", v, mpat[k]);
            end
            wr(A_CTRL, cfg);
        end

        // R7 manual select
        wr(A_SSEL, 8'h01);
        wr(A_CTRL, C_EN | C_MST | C_MAN);
        repeat (2) @(negedge clk);
        chk("R7 manual idle", ss_n_o, 1);
        wr(A_SSEL, 8'h02);
        chk("R7 follows reg", ss_n_o, 2);
        wr(A_DATA, 8'hC3);
        repeat (10) @(negedge clk);
        chk("R7 during xfer", ss_n_o, 2);
        wait_words(1);
        popr(v);

        // R8 and R13 slave role
        wr(A_CTRL, C_EN | C_MAN);
        repeat (2) @(negedge clk);
        chk("R8 ss none", ss_n_o, 3);
        chk("R8 oe", {sck_oe, mosi_oe, ss_oe}, 0);
        ss_i = 1'b0; #1;
        chk("R13 selected", miso_oe, 1);
        ss_i = 1'b1; #1;
        chk("R13 deselected", miso_oe, 0);

        // R9 loopback ignores miso
        wr(A_CTRL, C_MST | C_LOOP);
        for (int k = 0; k < 3; k++) begin
            txw[k] = 8'(8'h91 + k * 45);
            mpat[k] = 8'h0F;
            wr(A_DATA, txw[k]);
        end
        widx = 0;
        wr(A_CTRL, C_EN | C_MST | C_LOOP);
        wait_words(3);
        for (int k = 0; k < 3; k++) begin
            popr(v); chk("R9 loop word", v, txw[k]);
        end

        // R11 transmit full drop
        wr(A_CTRL, C_MST | C_LOOP);
        for (int k = 0; k < 5; k++) begin
            txw[k] = 8'(8'h21 + k * 19);
            wr(A_DATA, txw[k]);
        end
        rd(A_STAT, v); chk("R11 tx full", v[0], 1);
        wr(A_CTRL, C_EN | C_MST | C_LOOP);
        wait_words(5);
        for (int k = 0; k < 4; k++) begin
            popr(v); chk("R11 kept word", v, txw[k]);
        end
        rd(A_STAT, v); chk("R11 fifth dropped", v[3:0], 4'b1010);

        // R12 receive overrun
        for (int k = 0; k < 4; k++) begin
            txw[k] = 8'(8'h4B + k * 7);
            wr(A_DATA, txw[k]);
        end
        wait_words(4);
        rd(A_STAT, v); chk("R12 full no ovr", {v[4], v[2]}, 1);
        wr(A_DATA, 8'h77);
        wait_words(1);
        rd(A_STAT, v); chk("R12 ovr set", {v[4], v[2]}, 3);
        for (int k = 0; k < 2; k++) begin
            popr(v); chk("R12 early word", v, txw[k]);
        end
        wr(A_CTRL, C_EN | C_MST | C_LOOP | C_RXC);
        peek(A_CTRL, v); chk("R10 rxclr set", v[5], 1);
        @(negedge clk);
        peek(A_STAT, v); chk("R10 rx empty", v[3], 1);
        chk("R12 ovr sticky", v[4], 1);
        wr(A_STAT, 8'h10);
        peek(A_STAT, v); chk("R12 ovr cleared", v[4], 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule